// File: doc/BRIEF.md
# Two-Tap Averaging Stage with Request/Acknowledge Control

This block is a streaming two-tap averager. A producer offers a sample with a four-phase request/acknowledge handshake on the input side. The block returns the floor of the mean of that sample and the sample before it on an output handshake of the same kind. The stored history starts at zero after reset.

Inside, a small sequencer drives three internal request/acknowledge channels: one to a sample store, one to a history store and one to an adder with a fixed latency in clock cycles, which stands in for a matched-delay datapath. The producer is released as soon as the sample is held. It may then change the input bus while the average is still being delivered. The history takes the new sample only after the consumer has finished its handshake.

The block is a clocked model with parameterised data width and adder latency.

Top module: `hs_avg2_filter`

## Requirements
- R1: After synchronous reset, `in_ack` and `out_req` are low, `out_data` is zero and the history is zero, so the first result is the first sample divided by two.
- R2: Each result equals floor((x + y) / 2). Here x is the current sample and y is the previous accepted sample. The sum is formed DATA_W+1 bits wide and shifted right by one.
- R3: With the block idle, the edge that samples `in_req` high is edge 1. `in_ack` goes high after edge 3.
- R4: `in_ack` stays high while `in_req` is high. It goes low at the first edge that samples `in_req` low.
- R5: With the block idle, `out_req` goes high after edge ADD_DELAY+4, counting edge 1 as for R3.
- R6: While `out_req` is high and `out_ack` is low, `out_req` stays high and `out_data` holds its value.
- R7: `out_req` goes low at the first edge that samples `out_ack` high. It stays low while `out_ack` remains high.
- R8: Changes to `in_data` after `in_ack` has risen do not affect the result. A new `in_req` raised while a result is pending gets no `in_ack` until the output handshake has completed.
- R9: All-ones inputs give an all-ones result. The widened sum does not wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_req | input | 1 | Input sample valid (four-phase request) |
| in_ack | output | 1 | Input sample taken; the input bus may change |
| in_data | input | DATA_W | Input sample |
| out_req | output | 1 | Result valid (four-phase request) |
| out_ack | input | 1 | Consumer has taken the result |
| out_data | output | DATA_W | Averaged result |

## Verification
Counted from the edge that samples `in_req` in idle, `in_ack` is due after edge 3 and `out_req` after edge ADD_DELAY+4. `out_req` falls one edge after `out_ack` is sampled, and `in_ack` falls one edge after `in_req` drops. The bench drives inputs on the falling edge and samples 1 ns after each rising edge. It counts edges from the drive, so each latency check compares an exact edge index. A per-clock monitor compares `out_data` with the behaviourally computed mean on every cycle in which `out_req` is high.

// File: rtl/hs_avg2_pkg.sv
package hs_avg2_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_TAKE,
        PH_SUM,
        PH_SHOW,
        PH_RTZ,
        PH_KEEP,
        PH_DRAIN
    } phase_t;

    typedef struct packed {
        logic req;
        logic ack;
    } chan_t;

    function automatic int unsigned eff_delay(input int unsigned d);
        return (d < 1) ? 1 : d;
    endfunction

endpackage

// File: rtl/hs_avg2_store.sv
module hs_avg2_store #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [DATA_W-1:0] d,
    output logic              ack,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q   <= '0;
            ack <= 1'b0;
        end else begin
            ack <= req;
            if (req) q <= d;
        end
    end

    a_r2_ack_tracks_req: assert property (@(posedge clk) disable iff (rst)
        req |=> ack);
    a_r2_held_when_idle: assert property (@(posedge clk) disable iff (rst)
        !req |=> $stable(q));
endmodule

// File: rtl/hs_avg2_adder.sv
module hs_avg2_adder
    import hs_avg2_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int ADD_DELAY = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic              ack,
    output logic [DATA_W-1:0] mean
);
    localparam int unsigned DLY   = eff_delay(ADD_DELAY);
    localparam int          SUM_W = DATA_W + 1;

    logic [SUM_W-1:0] sum_q;

    generate
        if (DLY == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) begin
                    ack   <= 1'b0;
                    sum_q <= '0;
                end else begin
                    ack <= req;
                    if (req) sum_q <= SUM_W'(a) + SUM_W'(b);
                end
            end
        end else begin : g_count
            localparam int CNT_W = $clog2(DLY + 1);
            logic [CNT_W-1:0] cnt;
            always_ff @(posedge clk) begin
                if (rst) begin
                    ack   <= 1'b0;
                    cnt   <= '0;
                    sum_q <= '0;
                end else if (!req) begin
                    ack <= 1'b0;
                    cnt <= '0;
                end else begin
                    sum_q <= SUM_W'(a) + SUM_W'(b);
                    if (!ack) begin
                        if (cnt == CNT_W'(DLY - 1)) ack <= 1'b1;
                        else                        cnt <= cnt + 1'b1;
                    end
                end
            end
        end
    endgenerate

    assign mean = sum_q[SUM_W-1:1];

    a_r5_ack_needs_req: assert property (@(posedge clk) disable iff (rst)
        $rose(ack) |-> $past(req));
    a_r5_ack_drops: assert property (@(posedge clk) disable iff (rst)
        !req |=> !ack);
endmodule

// File: rtl/hs_avg2_ctrl.sv
module hs_avg2_ctrl
    import hs_avg2_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_req,
    output logic  in_ack,
    input  logic  out_ack,
    output logic  out_req,
    output logic  out_load,
    output chan_t smp_ch_req,
    input  logic  smp_ack,
    output chan_t sum_ch_req,
    input  logic  sum_ack,
    output chan_t his_ch_req,
    input  logic  his_ack
);
    phase_t ph, ph_nx;

    always_comb begin
        ph_nx = ph;
        unique case (ph)
            PH_IDLE:  if (in_req && !in_ack) ph_nx = PH_TAKE;
            PH_TAKE:  if (smp_ack)            ph_nx = PH_SUM;
            PH_SUM:   if (sum_ack)            ph_nx = PH_SHOW;
            PH_SHOW:  if (out_ack)            ph_nx = PH_RTZ;
            PH_RTZ:   if (!out_ack)           ph_nx = PH_KEEP;
            PH_KEEP:  if (his_ack)            ph_nx = PH_DRAIN;
            PH_DRAIN: if (!smp_ack && !sum_ack && !his_ack) ph_nx = PH_IDLE;
            default:                          ph_nx = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph     <= PH_IDLE;
            in_ack <= 1'b0;
        end else begin
            ph <= ph_nx;
            if (ph == PH_TAKE && smp_ack) in_ack <= 1'b1;
            else if (in_ack && !in_req)   in_ack <= 1'b0;
        end
    end

    always_comb begin
        smp_ch_req     = '0;
        sum_ch_req     = '0;
        his_ch_req     = '0;
        smp_ch_req.req = (ph == PH_TAKE);
        sum_ch_req.req = (ph == PH_SUM) || (ph == PH_SHOW) ||
                         (ph == PH_RTZ) || (ph == PH_KEEP);
        his_ch_req.req = (ph == PH_KEEP);
        smp_ch_req.ack = smp_ack;
        sum_ch_req.ack = sum_ack;
        his_ch_req.ack = his_ack;
    end

    assign out_req  = (ph == PH_SHOW);
    assign out_load = (ph == PH_SUM) && sum_ack;

    a_r4_in_ack_holds: assert property (@(posedge clk) disable iff (rst)
        (in_ack && in_req) |=> in_ack);
    a_r4_in_ack_falls: assert property (@(posedge clk) disable iff (rst)
        (in_ack && !in_req) |=> !in_ack);
    a_r7_out_req_falls: assert property (@(posedge clk) disable iff (rst)
        (out_req && out_ack) |=> !out_req);
    a_r5_out_after_sum: assert property (@(posedge clk) disable iff (rst)
        $rose(out_req) |-> $past(sum_ack));
    a_r8_hist_after_out: assert property (@(posedge clk) disable iff (rst)
        $rose(his_ch_req.req) |-> $past(!out_ack && !out_req));
    a_r8_no_overlap: assert property (@(posedge clk) disable iff (rst)
        $onehot0({smp_ch_req.req, his_ch_req.req, out_req}));
endmodule

// File: rtl/hs_avg2_filter.sv
module hs_avg2_filter
    import hs_avg2_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int ADD_DELAY = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_req,
    output logic              in_ack,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_req,
    input  logic              out_ack,
    output logic [DATA_W-1:0] out_data
);
    chan_t             smp_ch, sum_ch, his_ch;
    logic              smp_ack, sum_ack, his_ack, out_load;
    logic [DATA_W-1:0] smp_q, his_q, mean;
    logic [DATA_W-1:0] out_q;

    hs_avg2_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .in_req     (in_req),
        .in_ack     (in_ack),
        .out_ack    (out_ack),
        .out_req    (out_req),
        .out_load   (out_load),
        .smp_ch_req (smp_ch),
        .smp_ack    (smp_ack),
        .sum_ch_req (sum_ch),
        .sum_ack    (sum_ack),
        .his_ch_req (his_ch),
        .his_ack    (his_ack)
    );

    hs_avg2_store #(.DATA_W(DATA_W)) u_smp (
        .clk (clk), .rst (rst), .req (smp_ch.req), .d (in_data),
        .ack (smp_ack), .q (smp_q)
    );

    hs_avg2_store #(.DATA_W(DATA_W)) u_his (
        .clk (clk), .rst (rst), .req (his_ch.req), .d (smp_q),
        .ack (his_ack), .q (his_q)
    );

    hs_avg2_adder #(.DATA_W(DATA_W), .ADD_DELAY(ADD_DELAY)) u_add (
        .clk (clk), .rst (rst), .req (sum_ch.req), .a (smp_q), .b (his_q),
        .ack (sum_ack), .mean (mean)
    );

    always_ff @(posedge clk) begin
        if (rst)           out_q <= '0;
        else if (out_load) out_q <= mean;
    end

    assign out_data = out_q;

    a_r6_out_held: assert property (@(posedge clk) disable iff (rst)
        (out_req && !out_ack) |=> (out_req && $stable(out_data)));
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) |-> (!in_ack && !out_req));
endmodule

// File: tb/sim_hs_avg2_filter.sv
module sim_hs_avg2_filter;
    localparam int W = 8;
    localparam int D = 3;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_req = 1'b0;
    logic         out_ack = 1'b0;
    logic [W-1:0] in_data = '0;
    logic         in_ack, out_req;
    logic [W-1:0] out_data;

    int checks = 0;
    int fails  = 0;
    int hist   = 0;
    int exp_now = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    hs_avg2_filter #(.DATA_W(W), .ADD_DELAY(D)) u0 (
        .clk(clk), .rst(rst), .in_req(in_req), .in_ack(in_ack),
        .in_data(in_data), .out_req(out_req), .out_ack(out_ack),
        .out_data(out_data)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // R2 per-clock comparison against the behavioural mean
    always @(negedge clk) begin
        if (!rst && out_req && !done)
            chk(int'(out_data) == exp_now, "R2 monitor out_data", int'(out_data), exp_now);
    end

    task automatic run(input int v, input int hold_in, input int ack_wait,
                       input bit lat, input bit early, input int nxt);
        int n;
        int tot;
        exp_now = (v + hist) / 2;
        @(negedge clk);
        in_req  = 1'b1;
        in_data = W'(v);
        n = 0;
        do begin step(); n++; end while (!in_ack && n < 40);
        if (lat) chk(n == 3, "R3 in_ack edge", n, 3);
        tot = n;
        for (int i = 0; i < hold_in; i++) begin
            step(); tot++;
            chk(in_ack == 1'b1, "R4 in_ack held", int'(in_ack), 1);
        end
        @(negedge clk);
        in_req  = 1'b0;
        in_data = ~W'(v);            // R8: bus changes after release
        step(); tot++;
        chk(in_ack == 1'b0, "R4 in_ack falls", int'(in_ack), 0);
        while (!out_req && tot < 60) begin step(); tot++; end
        if (lat) chk(tot == D + 4, "R5 out_req edge", tot, D + 4);
        chk(int'(out_data) == exp_now, "R2 R8 result", int'(out_data), exp_now);
        if (early) begin
            @(negedge clk);
            in_req  = 1'b1;
            in_data = W'(nxt);
        end
        for (int i = 0; i < ack_wait; i++) begin
            step();
            chk(out_req == 1'b1, "R6 out_req held", int'(out_req), 1);
            chk(int'(out_data) == exp_now, "R6 out_data held", int'(out_data), exp_now);
            if (early) chk(in_ack == 1'b0, "R8 new sample blocked", int'(in_ack), 0);
        end
        @(negedge clk);
        out_ack = 1'b1;
        step();
        chk(out_req == 1'b0, "R7 out_req falls", int'(out_req), 0);
        for (int i = 0; i < 2; i++) begin
            step();
            chk(out_req == 1'b0, "R7 out_req stays low", int'(out_req), 0);
            if (early) chk(in_ack == 1'b0, "R8 blocked until rtz", int'(in_ack), 0);
        end
        @(negedge clk);
        out_ack = 1'b0;
        hist = v;
        if (!early) repeat (6) step();
    endtask

    initial begin
        repeat (3) step();
        @(negedge clk);
        rst = 1'b0;
        step();
        chk(in_ack == 1'b0, "R1 in_ack reset", int'(in_ack), 0);
        chk(out_req == 1'b0, "R1 out_req reset", int'(out_req), 0);
        chk(out_data == '0, "R1 out_data reset", int'(out_data), 0);
        run(10, 0, 0, 1'b1, 1'b0, 0);   // R1 history zero: 5
        run(200, 1, 3, 1'b1, 1'b0, 0);  // 105
        run(255, 0, 2, 1'b1, 1'b0, 0);  // 227
        run(255, 1, 1, 1'b1, 1'b0, 0);  // R9: 255
        run(0, 0, 0, 1'b1, 1'b0, 0);    // R2 truncation: 127
        run(7, 0, 4, 1'b1, 1'b1, 100);  // R8 early request: 3
        run(100, 0, 1, 1'b0, 1'b0, 0);  // 53
        run(1, 1, 2, 1'b1, 1'b0, 0);    // 50
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule